// File: doc/BRIEF.md
# Averaging Audio Sample Decimator

This block turns a stream of per-CPU-cycle sound channel levels into audio samples at a lower, programmable output rate. Five channel levels arrive on every clock whose CPU enable is high: two square-wave levels, a triangle level, a noise level and a 7-bit delta-modulation level. A fractional phase accumulator decides on which CPU cycle a sample is due. Between two such cycles, the block sums each channel group and counts the cycles. It then divides each sum by that count, which gives a box-car average rather than a single point sample.

The increment added to the phase each CPU cycle is `floor(2^32 * rate / 1789773)`. A carry out of the 32 fractional bits marks an output sample. The averages come from four sequential restoring dividers that run in parallel. A one-clock valid strobe marks the clock in which all four quotients are present on the outputs.

Loading a new rate starts the same kind of sequential divider to derive the new increment. A five-bit mute mask can silence any channel before it is accumulated.

Top module: `audio_decimator`

## Requirements
- R1: While `rst_n` is low, and after reset until the first sample, `smp_valid` is 0 and all four average outputs are 0. Reset clears the phase, the accumulators and the cycle count, and makes the active rate 44100.
- R2: On each effective CPU cycle the phase gains `floor(2^32 * rate / 1789773)`. When the sum reaches 2^32, the carry is dropped, the low 32 bits are kept, and a sample is emitted on that cycle.
- R3: Each effective CPU cycle, including the emitting one, adds `sq1_lvl + sq2_lvl` to the square accumulator and each other level to its own accumulator, and adds one to the cycle count. After an emission, all accumulators and the count are zero. Clocks with `cpu_ce` low are not counted.
- R4: Each emitted sample yields `floor(sum / count)` per group, with a count of zero treated as 1. The result is shown on `avg_sq`, `avg_tri`, `avg_noi` and `avg_dmc` together with a one-clock `smp_valid` pulse. That pulse comes exactly 28 clock edges after the emitting edge, and exactly one pulse follows each emission.
- R5: `mute` bit 0 forces `sq1_lvl` to zero before accumulation, bit 1 `sq2_lvl`, bit 2 `tri_lvl`, bit 3 `noi_lvl` and bit 4 `dmc_lvl`.
- R6: A `rate_ld` with `rate_in` equal to 0, or equal to the active rate, has no effect. The phase, the sums and the count carry on unchanged.
- R7: Any other `rate_ld` makes `rate_in` the active rate, clears the phase, the accumulators and the count, and discards that edge's CPU cycle, so no sample is emitted on it. `cpu_ce` is also ignored on the 53 following clock edges, after which the new increment is in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_ce | input | 1 | Marks a clock that is one CPU cycle |
| sq1_lvl | input | 4 | First square channel level |
| sq2_lvl | input | 4 | Second square channel level |
| tri_lvl | input | 4 | Triangle channel level |
| noi_lvl | input | 4 | Noise channel level |
| dmc_lvl | input | 7 | Delta-modulation channel level |
| mute | input | 5 | Per-channel silence mask |
| rate_ld | input | 1 | Strobe that offers a new output rate |
| rate_in | input | 20 | Offered output rate in samples per second |
| smp_valid | output | 1 | One-clock strobe: averages are valid |
| avg_sq | output | 5 | Average of the summed square levels |
| avg_tri | output | 4 | Average triangle level |
| avg_noi | output | 4 | Average noise level |
| avg_dmc | output | 7 | Average delta-modulation level |

## Verification
A rate load and a sample emission can fall on the same CPU cycle, and the load must win: the cycle is dropped and nothing is emitted. The bench steps its own model of the phase until the model predicts a carry on the next enabled cycle, and offers a new rate on exactly that edge. It then judges that no valid strobe appears for the lost sample, and that every later sample matches the model in value and arrival clock under the new increment.

// File: rtl/adec_pkg.sv
package adec_pkg;
  localparam int PH_FRAC = 32;
  localparam int NGRP    = 4;
  typedef enum int {GRP_SQ = 0, GRP_TRI = 1, GRP_NOI = 2, GRP_DMC = 3} grp_e;
endpackage

// File: rtl/adec_div.sv
module adec_div #(
  parameter int NUM_W = 28,
  parameter int DEN_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int STEP_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0]  rem_q, rem_d, den_q, den_d;
  logic [NUM_W-1:0]  nq_q, nq_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              busy_d, done_d;
  logic [DEN_W:0]    trial;

  always_comb begin
    trial  = {rem_q, nq_q[NUM_W-1]};
    rem_d  = rem_q;
    nq_d   = nq_q;
    den_d  = den_q;
    step_d = step_q;
    busy_d = busy;
    done_d = 1'b0;
    if (start) begin
      rem_d  = '0;
      nq_d   = num;
      den_d  = den;
      step_d = STEP_W'(NUM_W);
      busy_d = 1'b1;
    end else if (busy) begin
      if (trial >= {1'b0, den_q}) begin
        rem_d = DEN_W'(trial - {1'b0, den_q});
        nq_d  = {nq_q[NUM_W-2:0], 1'b1};
      end else begin
        rem_d = trial[DEN_W-1:0];
        nq_d  = {nq_q[NUM_W-2:0], 1'b0};
      end
      step_d = step_q - STEP_W'(1);
      if (step_q == STEP_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      nq_q   <= '0;
      den_q  <= '0;
      step_q <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      nq_q   <= nq_d;
      den_q  <= den_d;
      step_q <= step_d;
      busy   <= busy_d;
      done   <= done_d;
    end
  end

  assign quo = nq_q;

  // R4: completion only ever ends a running division
  a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  // R4: a start always leaves the divider running
  a_r4_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/adec_phase.sv
module adec_phase import adec_pkg::*; #(
  parameter int CLK_HZ   = 1789773,
  parameter int RATE_W   = 20,
  parameter int DEF_RATE = 44100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              rate_ld,
  input  logic [RATE_W-1:0] rate_in,
  output logic              tick,
  output logic              emit,
  output logic              clr
);
  localparam int CLK_W     = $clog2(CLK_HZ + 1);
  localparam int INC_NUM_W = RATE_W + PH_FRAC;
  localparam logic [63:0] DEF_INC64 = (64'(DEF_RATE) << PH_FRAC) / 64'(CLK_HZ);

  logic [RATE_W-1:0]    rate_q, rate_d;
  logic [PH_FRAC-1:0]   inc_q, inc_d, phase_q, phase_d;
  logic [PH_FRAC:0]     sum;
  logic                 ld_ok, ib, idn;
  logic [INC_NUM_W-1:0] iq;

  assign ld_ok = rate_ld && (rate_in != '0) && (rate_in != rate_q);

  adec_div #(.NUM_W(INC_NUM_W), .DEN_W(CLK_W)) u_inc_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ld_ok),
    .num   ({rate_in, {PH_FRAC{1'b0}}}),
    .den   (CLK_W'(CLK_HZ)),
    .busy  (ib),
    .done  (idn),
    .quo   (iq)
  );

  assign tick = ce && !ib && !idn && !ld_ok;
  assign sum  = {1'b0, phase_q} + {1'b0, inc_q};
  assign emit = tick && sum[PH_FRAC];
  assign clr  = ld_ok;

  always_comb begin
    rate_d  = rate_q;
    inc_d   = inc_q;
    phase_d = phase_q;
    if (ld_ok) begin
      rate_d  = rate_in;
      phase_d = '0;
    end else if (tick) begin
      phase_d = sum[PH_FRAC-1:0];
    end
    if (idn) inc_d = iq[PH_FRAC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= RATE_W'(DEF_RATE);
      inc_q   <= DEF_INC64[PH_FRAC-1:0];
      phase_q <= '0;
    end else begin
      rate_q  <= rate_d;
      inc_q   <= inc_d;
      phase_q <= phase_d;
    end
  end

  // R2: a rate below the clock gives an increment below one full turn
  a_r2_inc_fits: assert property (@(posedge clk) disable iff (!rst_n)
    idn |-> (iq[INC_NUM_W-1:PH_FRAC] == '0));
  // R6: a zero rate leaves the active rate alone
  a_r6_zero_rate_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_ld && rate_in == '0) |=> $stable(rate_q));
  // R7: the edge after an accepted load takes no CPU cycle
  a_r7_ce_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !tick);
endmodule

// File: rtl/adec_accum.sv
module adec_accum #(
  parameter int NGRP  = 4,
  parameter int ACC_W = 28,
  parameter int CNT_W = 21
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       emit,
  input  logic                       clr,
  input  logic [NGRP-1:0][ACC_W-1:0] lvl,
  output logic [NGRP-1:0][ACC_W-1:0] num,
  output logic [CNT_W-1:0]           cnt
);
  logic [NGRP-1:0][ACC_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0]           cnt_q, cnt_d;

  always_comb begin
    cnt = cnt_q + CNT_W'(1);
    for (int g = 0; g < NGRP; g++) num[g] = acc_q[g] + lvl[g];
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (clr || emit) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (tick) begin
      acc_d = num;
      cnt_d = cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  // R3: an emission leaves the cycle count empty
  a_r3_clear_after_emit: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> (cnt_q == '0));
endmodule

// File: rtl/audio_decimator.sv
module audio_decimator import adec_pkg::*; #(
  parameter int CLK_HZ   = 1789773,
  parameter int RATE_W   = 20,
  parameter int DEF_RATE = 44100,
  parameter int SQ_W     = 4,
  parameter int TRI_W    = 4,
  parameter int NOI_W    = 4,
  parameter int DMC_W    = 7,
  parameter int CNT_W    = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ce,
  input  logic [SQ_W-1:0]   sq1_lvl,
  input  logic [SQ_W-1:0]   sq2_lvl,
  input  logic [TRI_W-1:0]  tri_lvl,
  input  logic [NOI_W-1:0]  noi_lvl,
  input  logic [DMC_W-1:0]  dmc_lvl,
  input  logic [4:0]        mute,
  input  logic              rate_ld,
  input  logic [RATE_W-1:0] rate_in,
  output logic              smp_valid,
  output logic [SQ_W:0]     avg_sq,
  output logic [TRI_W-1:0]  avg_tri,
  output logic [NOI_W-1:0]  avg_noi,
  output logic [DMC_W-1:0]  avg_dmc
);
  localparam int W_A     = (SQ_W + 1 > TRI_W) ? SQ_W + 1 : TRI_W;
  localparam int W_B     = (NOI_W > DMC_W) ? NOI_W : DMC_W;
  localparam int LVL_MAX = (W_A > W_B) ? W_A : W_B;
  localparam int ACC_W   = LVL_MAX + CNT_W;

  logic                       tick, emit, clr;
  logic [NGRP-1:0][ACC_W-1:0] lvl, num, quo;
  logic [CNT_W-1:0]           cnt, den;
  logic [NGRP-1:0]            dbusy, ddone;

  always_comb begin
    lvl[GRP_SQ]  = (mute[0] ? '0 : ACC_W'(sq1_lvl)) + (mute[1] ? '0 : ACC_W'(sq2_lvl));
    lvl[GRP_TRI] = mute[2] ? '0 : ACC_W'(tri_lvl);
    lvl[GRP_NOI] = mute[3] ? '0 : ACC_W'(noi_lvl);
    lvl[GRP_DMC] = mute[4] ? '0 : ACC_W'(dmc_lvl);
  end

  adec_phase #(.CLK_HZ(CLK_HZ), .RATE_W(RATE_W), .DEF_RATE(DEF_RATE)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (cpu_ce),
    .rate_ld (rate_ld),
    .rate_in (rate_in),
    .tick    (tick),
    .emit    (emit),
    .clr     (clr)
  );

  adec_accum #(.NGRP(NGRP), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .emit  (emit),
    .clr   (clr),
    .lvl   (lvl),
    .num   (num),
    .cnt   (cnt)
  );

  assign den = (cnt == '0) ? CNT_W'(1) : cnt;

  for (genvar g = 0; g < NGRP; g++) begin : g_avg
    adec_div #(.NUM_W(ACC_W), .DEN_W(CNT_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (emit),
      .num   (num[g]),
      .den   (den),
      .busy  (dbusy[g]),
      .done  (ddone[g]),
      .quo   (quo[g])
    );
  end

  assign smp_valid = &ddone;
  assign avg_sq    = quo[GRP_SQ][SQ_W:0];
  assign avg_tri   = quo[GRP_TRI][TRI_W-1:0];
  assign avg_noi   = quo[GRP_NOI][NOI_W-1:0];
  assign avg_dmc   = quo[GRP_DMC][DMC_W-1:0];

  // R4: samples must be spaced so that no division is still running
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (dbusy == '0));
  // R4: the valid strobe lasts one clock
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);
  // R4: an average never exceeds the widest level of its group
  a_r4_avg_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (quo[GRP_SQ][ACC_W-1:SQ_W+1] == '0) && (quo[GRP_TRI][ACC_W-1:TRI_W] == '0)
               && (quo[GRP_NOI][ACC_W-1:NOI_W] == '0) && (quo[GRP_DMC][ACC_W-1:DMC_W] == '0));
endmodule

// File: tb/tb_audio_decimator.sv
module tb_audio_decimator;
  localparam int     LAT   = 28;
  localparam longint CLKHZ = 1789773;
  localparam longint TURN  = 64'h1_0000_0000;
  // row: sq1 sq2 tri noi dmc mute len
  localparam int NROW = 8;
  localparam logic [43:0] VEC [NROW] = '{
    {4'd15, 4'd15, 4'd15, 4'd15, 7'd127, 5'b00000, 16'd200},
    {4'd3,  4'd7,  4'd9,  4'd1,  7'd64,  5'b00000, 16'd150},
    {4'd15, 4'd15, 4'd15, 4'd15, 7'd127, 5'b00001, 16'd120},
    {4'd12, 4'd5,  4'd6,  4'd7,  7'd99,  5'b00010, 16'd120},
    {4'd9,  4'd9,  4'd13, 4'd2,  7'd17,  5'b00100, 16'd120},
    {4'd1,  4'd14, 4'd4,  4'd11, 7'd80,  5'b01000, 16'd120},
    {4'd6,  4'd2,  4'd8,  4'd10, 7'd120, 5'b10000, 16'd120},
    {4'd5,  4'd0,  4'd2,  4'd14, 7'd33,  5'b00000, 16'd90}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cpu_ce, rate_ld, smp_valid;
  logic [3:0]  sq1_lvl, sq2_lvl, tri_lvl, noi_lvl, avg_tri, avg_noi;
  logic [6:0]  dmc_lvl, avg_dmc;
  logic [4:0]  mute, avg_sq;
  logic [19:0] rate_in;

  audio_decimator dut (.*);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  longint m_rate, m_inc, m_ph, s_sq, s_tri, s_noi, s_dmc, m_cnt;
  int blk_until = -1;
  longint e_sq[64], e_tri[64], e_noi[64], e_dmc[64];
  int e_due[64];
  string e_tag[64];
  int head = 0, tail = 0, n_valid = 0, n_push = 0;
  string tag = "R1";

  task automatic check(input bit ok, input string msg, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic model_clear();
    s_sq = 0; s_tri = 0; s_noi = 0; s_dmc = 0; m_cnt = 0;
  endtask

  task automatic step(input int a, input int b, input int t, input int n, input int d,
                      input logic [4:0] mk, input bit ce, input bit ld, input int rt);
    int edge_i;
    @(negedge clk);
    sq1_lvl = 4'(a); sq2_lvl = 4'(b); tri_lvl = 4'(t); noi_lvl = 4'(n); dmc_lvl = 7'(d);
    mute = mk; cpu_ce = ce; rate_ld = ld; rate_in = 20'(rt);
    edge_i = cyc + 1;
    if (ld && rt != 0 && longint'(rt) != m_rate) begin
      m_rate = rt;
      m_inc = (longint'(rt) << 32) / CLKHZ;
      m_ph = 0;
      model_clear();
      blk_until = edge_i + 53;
    end else if (ce && edge_i > blk_until) begin
      s_sq  += (mk[0] ? 0 : a) + (mk[1] ? 0 : b);
      s_tri += mk[2] ? 0 : t;
      s_noi += mk[3] ? 0 : n;
      s_dmc += mk[4] ? 0 : d;
      m_cnt++;
      m_ph += m_inc;
      if (m_ph >= TURN) begin
        m_ph -= TURN;
        e_sq[tail % 64] = s_sq / m_cnt;  e_tri[tail % 64] = s_tri / m_cnt;
        e_noi[tail % 64] = s_noi / m_cnt; e_dmc[tail % 64] = s_dmc / m_cnt;
        e_due[tail % 64] = edge_i + LAT; e_tag[tail % 64] = tag;
        tail++; n_push++;
        model_clear();
      end
    end
  endtask

  // sample monitor: values and arrival clock against the model
  always @(negedge clk) if (rst_n) begin
    if (smp_valid) begin
      n_valid++;
      checks++;
      if (head == tail) begin
        errors++;
        $display("FAIL R4 unexpected sample at cycle %0d: valid actual 1 expected 0", cyc);
      end else begin
        if (cyc != e_due[head % 64] || longint'(avg_sq) != e_sq[head % 64] ||
            longint'(avg_tri) != e_tri[head % 64] || longint'(avg_noi) != e_noi[head % 64] ||
            longint'(avg_dmc) != e_dmc[head % 64]) begin
          errors++;
          $display("FAIL %s R4 sample: actual cyc %0d sq %0d tri %0d noi %0d dmc %0d expected cyc %0d sq %0d tri %0d noi %0d dmc %0d",
                   e_tag[head % 64], cyc, avg_sq, avg_tri, avg_noi, avg_dmc, e_due[head % 64],
                   e_sq[head % 64], e_tri[head % 64], e_noi[head % 64], e_dmc[head % 64]);
        end
        head++;
      end
    end else if (head != tail && cyc > e_due[head % 64]) begin
      checks++; errors++;
      $display("FAIL %s R4 missing sample: valid actual 0 expected 1 at cycle %0d", e_tag[head % 64], e_due[head % 64]);
      head++;
    end
  end

  always @(posedge clk) if (cyc > 100000) begin
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_ce = 1'b1; rate_ld = 1'b0; rate_in = 20'd0; mute = 5'd0;
    sq1_lvl = 4'd9; sq2_lvl = 4'd9; tri_lvl = 4'd9; noi_lvl = 4'd9; dmc_lvl = 7'd99;
    m_rate = 44100; m_inc = (longint'(44100) << 32) / CLKHZ; m_ph = 0;
    model_clear();
    repeat (60) @(negedge clk);
    // R1: reset holds outputs quiet even with the CPU enable high
    check(smp_valid == 1'b0, "R1 valid in reset", longint'(smp_valid), 0);
    check(avg_sq == 5'd0 && avg_tri == 4'd0, "R1 sq/tri in reset", longint'(avg_sq) + longint'(avg_tri), 0);
    check(avg_noi == 4'd0 && avg_dmc == 7'd0, "R1 noi/dmc in reset", longint'(avg_noi) + longint'(avg_dmc), 0);
    cpu_ce = 1'b0;
    rst_n = 1'b1;

    // table walk: R2 R3 R4 with R5 mask rows
    for (int r = 0; r < NROW; r++) begin
      tag = (VEC[r][20:16] != 5'd0) ? "R5" : "R2 R3";
      for (int k = 0; k < int'(VEC[r][15:0]); k++)
        step(int'(VEC[r][43:40]), int'(VEC[r][39:36]), int'(VEC[r][35:32]), int'(VEC[r][31:28]),
             int'(VEC[r][27:21]), VEC[r][20:16], 1'b1, 1'b0, 0);
    end

    // R3: gaps in the CPU enable are not counted
    tag = "R3 gaps";
    for (int k = 0; k < 400; k++)
      step(k % 16, (k * 3) % 16, (k * 5) % 16, (k * 7) % 16, (k * 11) % 128, 5'd0, (k % 3) != 0, 1'b0, 0);

    // R6: loads of the active rate and of zero are ignored
    tag = "R6";
    for (int k = 0; k < 200; k++)
      step(k % 16, 15, (k * 5) % 16, 3, (k * 13) % 128, 5'd0, 1'b1, (k == 30) || (k == 95), (k == 30) ? 44100 : 0);

    // R7: new rate, CPU cycles during recompute are dropped
    tag = "R7";
    step(15, 15, 15, 15, 127, 5'd0, 1'b1, 1'b1, 22050);
    for (int k = 0; k < 40; k++) step(15, 15, 15, 15, 127, 5'd0, 1'b1, 1'b0, 0);
    for (int k = 0; k < 20; k++) step(0, 0, 0, 0, 0, 5'd0, 1'b0, 1'b0, 0);
    for (int k = 0; k < 500; k++)
      step(k % 16, (k * 7) % 16, (k * 3) % 16, (k * 9) % 16, (k * 5) % 128, 5'd0, 1'b1, 1'b0, 0);

    // R7: a load on the very edge that would emit wins over the emission
    tag = "R7 collide";
    for (int k = 0; k < 200 && (m_ph + m_inc) < TURN; k++)
      step(4, 4, 4, 4, 40, 5'd0, 1'b1, 1'b0, 0);
    check((m_ph + m_inc) >= TURN, "R7 collision edge reached", m_ph + m_inc, TURN);
    step(4, 4, 4, 4, 40, 5'd0, 1'b1, 1'b1, 48000);
    for (int k = 0; k < 60; k++) step(0, 0, 0, 0, 0, 5'd0, 1'b0, 1'b0, 0);
    for (int k = 0; k < 300; k++)
      step((k * 5) % 16, k % 16, 7, (k * 3) % 16, (k * 17) % 128, 5'd0, 1'b1, 1'b0, 0);

    for (int k = 0; k < 40; k++) step(0, 0, 0, 0, 0, 5'd0, 1'b0, 1'b0, 0);
    check(head == tail, "R4 all predicted samples seen", longint'(tail - head), 0);
    check(n_valid == n_push, "R4 one strobe per emission", longint'(n_valid), longint'(n_push));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule